// File: doc/BRIEF.md
# Host Mailbox with Indirect Shared SRAM

This block sits between a host byte bus and an embedded sequencer that share a 256-byte SRAM. The host never sees the SRAM directly: it loads a byte offset into a pointer register, then reads or writes a window register to reach that byte. The other registers hold the sequencer handshake: a request flag, a job start address, and a status register with an acknowledge bit and an error bit.

A job runs in two phases. The host stores the job's start offset, then sets the request flag. The sequencer answers by setting acknowledge, or error on failure. The host then clears its request, and the sequencer drops acknowledge when the job is done. The SRAM belongs to the host only while both request and acknowledge are clear. At all other times it belongs to the sequencer, which reaches it through its own port. A selector/identity register pair reports which register layout the block uses. The layout is picked by a parameter.

Top module: `hmb_top`

## Requirements
- R1: After synchronous reset, host_rdata is 0x00 and seq_req is 0. seq_start is 0x00. Reading the pointer, command and status registers returns 0x00.
- R2: A write to the pointer register selects an SRAM byte, and the pointer reads back as written. Each register read is requested with a one-cycle host_rd strobe, and its data is on host_rdata in the cycle after the strobe. A window write stores the byte at the selected offset, and a later window read returns it. With the default layout the pointer is at offset 0x12 and the window at 0x13.
- R3: The host owns the SRAM only while the request flag and ACK are both 0. When it does not, window writes leave the SRAM unchanged and window reads return 0x00.
- R4: Bit 0 of a write to the command register (0x14) sets the request flag, which drives seq_req. The job start register (0x15) drives seq_start. Both read back as written, the command register as {7'b0, flag}.
- R5: The status register at 0x18 reads {6'b0, ERR, ACK}. While seq_req is 1, a seq_accept pulse sets ACK and a seq_fail pulse sets ERR. While seq_req is 0, both pulses have no effect.
- R6: A seq_done pulse clears ACK. ERR stays set through the release of the request and through seq_done. A 0-to-1 change of the request flag clears both ACK and ERR.
- R7: When the selector register (0x16) holds 0x1F, a read of 0x17 returns the layout version: 0x01 by default, 0x00 for the older layout. For any other selector value, 0x17 reads 0x00. The selector reads back as written.
- R8: While the sequencer owns the SRAM, its port writes and reads the memory, and read data appears on seq_mem_rdata one cycle after the request. While the host owns the SRAM, sequencer writes are ignored.
- R9: Unmapped offsets read 0x00. Writes to the status register have no effect.
- R10: With LAYOUT_VER = 0, the pointer is at offset 0x0A and the window at 0x0D. Offset 0x17 then reads 0x00 under the 0x1F selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after host_rd |
| seq_req | output | 1 | Request flag to the sequencer |
| seq_start | output | 8 | Job start offset for the sequencer |
| seq_accept | input | 1 | Sequencer pulse: job accepted (sets ACK) |
| seq_fail | input | 1 | Sequencer pulse: job failed (sets ERR) |
| seq_done | input | 1 | Sequencer pulse: job finished (clears ACK) |
| seq_mem_en | input | 1 | Sequencer SRAM access enable |
| seq_mem_we | input | 1 | Sequencer SRAM write enable |
| seq_mem_addr | input | 8 | Sequencer SRAM byte offset |
| seq_mem_wdata | input | 8 | Sequencer SRAM write data |
| seq_mem_rdata | output | 8 | SRAM read data, one cycle after the access |

## Verification
The hardest window to reach is the one after the host has released its request but the sequencer still holds ACK. In that window the flag is clear, yet the SRAM must stay locked, and ERR must survive both the release and the done pulse. The stimulus walks through the handshake one phase at a time. At each phase it attempts a window write and a window read. The sequencer writes the memory while it owns it, and again after ownership has returned to the host. A final readback shows which of those writes landed. A full sweep of all 256 offsets sets up the memory contents that these probes are compared against.

// File: rtl/hmb_pkg.sv
`timescale 1ns/1ps
package hmb_pkg;
    localparam int DW      = 8;
    localparam int MEM_AW  = 8;
    localparam int MEM_DEPTH = 1 << MEM_AW;

    localparam logic [7:0] OFF_CMD  = 8'h14;
    localparam logic [7:0] OFF_MSG  = 8'h15;
    localparam logic [7:0] OFF_SEL  = 8'h16;
    localparam logic [7:0] OFF_ID   = 8'h17;
    localparam logic [7:0] OFF_STAT = 8'h18;
    localparam logic [7:0] ID_KEY   = 8'h1F;

    typedef enum logic [2:0] {
        RS_NONE, RS_PTR, RS_WIN, RS_CMD, RS_MSG, RS_SEL, RS_ID, RS_STAT
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [MEM_AW-1:0] addr;
        logic [DW-1:0]     wdata;
    } mem_op_t;

    function automatic logic [7:0] ptr_off(input logic [7:0] ver);
        return (ver == 8'h00) ? 8'h0A : 8'h12;
    endfunction

    function automatic logic [7:0] win_off(input logic [7:0] ver);
        return (ver == 8'h00) ? 8'h0D : 8'h13;
    endfunction

    function automatic reg_sel_e decode(input logic [7:0] off, input logic [7:0] ver);
        reg_sel_e s;
        s = RS_NONE;
        if (off == ptr_off(ver))      s = RS_PTR;
        else if (off == win_off(ver)) s = RS_WIN;
        else if (off == OFF_CMD)      s = RS_CMD;
        else if (off == OFF_MSG)      s = RS_MSG;
        else if (off == OFF_SEL)      s = RS_SEL;
        else if (off == OFF_ID)       s = RS_ID;
        else if (off == OFF_STAT)     s = RS_STAT;
        return s;
    endfunction
endpackage

// File: rtl/hmb_handshake.sv
`timescale 1ns/1ps
module hmb_handshake (
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic cmd_bit,
    input  logic seq_accept,
    input  logic seq_fail,
    input  logic seq_done,
    output logic req_q,
    output logic ack_q,
    output logic err_q
);
    logic rise;
    assign rise = cmd_wr && cmd_bit && !req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (cmd_wr) req_q <= cmd_bit;
            if (rise) begin
                ack_q <= 1'b0;
                err_q <= 1'b0;
            end else begin
                if (req_q && seq_accept) ack_q <= 1'b1;
                if (seq_done)            ack_q <= 1'b0;
                if (req_q && seq_fail)   err_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hmb_sram.sv
`timescale 1ns/1ps
module hmb_sram
    import hmb_pkg::*;
#(
    parameter int AW = MEM_AW,
    parameter int W  = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_own,
    input  mem_op_t      host_op,
    input  mem_op_t      seq_op,
    output logic [W-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    mem_op_t      port;

    always_comb port = host_own ? host_op : seq_op;

    always_ff @(posedge clk) begin
        if (port.en && port.we) mem[port.addr[AW-1:0]] <= port.wdata[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                       rdata_q <= '0;
        else if (port.en && !port.we)  rdata_q <= mem[port.addr[AW-1:0]];
    end
endmodule

// File: rtl/hmb_regfile.sv
`timescale 1ns/1ps
module hmb_regfile
    import hmb_pkg::*;
#(
    parameter logic [7:0] LAYOUT_VER = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          req_q,
    input  logic          ack_q,
    input  logic          err_q,
    input  logic          host_own,
    output logic          cmd_wr,
    output logic          cmd_bit,
    output logic [DW-1:0] msg_q,
    output mem_op_t       host_op,
    output logic [DW-1:0] rd_q,
    output logic          rd_mem_q
);
    reg_sel_e          sel;
    logic [MEM_AW-1:0] ptr_q;
    logic [DW-1:0]     idsel_q;
    logic [DW-1:0]     rd_next;

    always_comb sel = decode(host_addr, LAYOUT_VER);

    assign cmd_wr  = host_wr && (sel == RS_CMD);
    assign cmd_bit = host_wdata[0];

    always_comb begin
        host_op.en    = host_own && (host_wr || host_rd) && (sel == RS_WIN);
        host_op.we    = host_wr;
        host_op.addr  = ptr_q;
        host_op.wdata = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            msg_q   <= '0;
            idsel_q <= '0;
        end else if (host_wr) begin
            case (sel)
                RS_PTR:  ptr_q   <= host_wdata[MEM_AW-1:0];
                RS_MSG:  msg_q   <= host_wdata;
                RS_SEL:  idsel_q <= host_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_next = '0;
        case (sel)
            RS_PTR:  rd_next = DW'(ptr_q);
            RS_CMD:  rd_next = {{(DW-1){1'b0}}, req_q};
            RS_MSG:  rd_next = msg_q;
            RS_SEL:  rd_next = idsel_q;
            RS_ID:   rd_next = (idsel_q == ID_KEY) ? LAYOUT_VER : '0;
            RS_STAT: rd_next = {{(DW-2){1'b0}}, err_q, ack_q};
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= '0;
            rd_mem_q <= 1'b0;
        end else if (host_rd) begin
            rd_q     <= rd_next;
            rd_mem_q <= host_own && (sel == RS_WIN) && !host_wr;
        end
    end
endmodule

// File: rtl/hmb_top.sv
`timescale 1ns/1ps
module hmb_top
    import hmb_pkg::*;
#(
    parameter logic [7:0] LAYOUT_VER = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       seq_req,
    output logic [7:0] seq_start,
    input  logic       seq_accept,
    input  logic       seq_fail,
    input  logic       seq_done,
    input  logic       seq_mem_en,
    input  logic       seq_mem_we,
    input  logic [7:0] seq_mem_addr,
    input  logic [7:0] seq_mem_wdata,
    output logic [7:0] seq_mem_rdata
);
    logic          req_q, ack_q, err_q;
    logic          cmd_wr, cmd_bit;
    logic          host_own;
    mem_op_t       host_op, seq_op;
    logic [DW-1:0] rd_q, mem_q;
    logic          rd_mem_q;

    assign host_own = !req_q && !ack_q;

    always_comb begin
        seq_op.en    = seq_mem_en;
        seq_op.we    = seq_mem_we;
        seq_op.addr  = seq_mem_addr[MEM_AW-1:0];
        seq_op.wdata = seq_mem_wdata;
    end

    hmb_handshake u_hs (
        .clk(clk), .rst(rst),
        .cmd_wr(cmd_wr), .cmd_bit(cmd_bit),
        .seq_accept(seq_accept), .seq_fail(seq_fail), .seq_done(seq_done),
        .req_q(req_q), .ack_q(ack_q), .err_q(err_q)
    );

    hmb_regfile #(.LAYOUT_VER(LAYOUT_VER)) u_rf (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .req_q(req_q), .ack_q(ack_q), .err_q(err_q), .host_own(host_own),
        .cmd_wr(cmd_wr), .cmd_bit(cmd_bit), .msg_q(seq_start),
        .host_op(host_op), .rd_q(rd_q), .rd_mem_q(rd_mem_q)
    );

    hmb_sram #(.AW(MEM_AW), .W(DW)) u_mem (
        .clk(clk), .rst(rst), .host_own(host_own),
        .host_op(host_op), .seq_op(seq_op), .rdata_q(mem_q)
    );

    assign seq_req       = req_q;
    assign seq_mem_rdata = mem_q;
    assign host_rdata    = rd_mem_q ? mem_q : rd_q;
endmodule

// File: rtl/hmb_checker.sv
`timescale 1ns/1ps
module hmb_checker
    import hmb_pkg::*;
#(
    parameter logic [7:0] LAYOUT_VER = 8'h01
) (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       seq_req,
    input logic       seq_accept,
    input logic       seq_fail,
    input logic       seq_done,
    input logic       ack_q,
    input logic       err_q
);
    logic req_rise;
    assign req_rise = host_wr && (host_addr == OFF_CMD) && host_wdata[0] && !seq_req;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (host_rdata == 8'h00 && !seq_req));

    assert_locked_read_R3: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_addr == win_off(LAYOUT_VER) && (seq_req || ack_q))
        |=> host_rdata == 8'h00);

    assert_cmd_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFF_CMD) |=> seq_req == $past(host_wdata[0]));

    assert_accept_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_req && seq_accept && !seq_done) |=> ack_q);

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !ack_q);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (err_q && !req_rise) |=> err_q);

    assert_rise_clears_R6: assert property (@(posedge clk) disable iff (rst)
        req_rise |=> (!ack_q && !err_q));
endmodule

bind hmb_top hmb_checker #(.LAYOUT_VER(LAYOUT_VER)) u_chk (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .seq_req(seq_req), .seq_accept(seq_accept), .seq_fail(seq_fail),
    .seq_done(seq_done), .ack_q(ack_q), .err_q(err_q)
);

// File: tb/tb_hmb_top.sv
`timescale 1ns/1ps
module tb_hmb_top;
    localparam logic [7:0] PTR = 8'h12, WIN = 8'h13, CMD = 8'h14, MSG = 8'h15;
    localparam logic [7:0] SEL = 8'h16, ID = 8'h17, STAT = 8'h18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 0, host_rd = 0;
    logic [7:0] host_addr = 0, host_wdata = 0;
    logic [7:0] host_rdata, rdata_v0, seq_start, seq_start_v0, seq_mem_rdata, smr_v0;
    logic seq_req, seq_req_v0;
    logic seq_accept = 0, seq_fail = 0, seq_done = 0;
    logic seq_mem_en = 0, seq_mem_we = 0;
    logic [7:0] seq_mem_addr = 0, seq_mem_wdata = 0;

    int checks = 0, errors = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] got;

    always #2.5 clk = ~clk;

    hmb_top dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_req(seq_req), .seq_start(seq_start),
        .seq_accept(seq_accept), .seq_fail(seq_fail), .seq_done(seq_done),
        .seq_mem_en(seq_mem_en), .seq_mem_we(seq_mem_we), .seq_mem_addr(seq_mem_addr),
        .seq_mem_wdata(seq_mem_wdata), .seq_mem_rdata(seq_mem_rdata)
    );

    hmb_top #(.LAYOUT_VER(8'h00)) dut_v0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_v0),
        .seq_req(seq_req_v0), .seq_start(seq_start_v0),
        .seq_accept(seq_accept), .seq_fail(seq_fail), .seq_done(seq_done),
        .seq_mem_en(seq_mem_en), .seq_mem_we(seq_mem_we), .seq_mem_addr(seq_mem_addr),
        .seq_mem_wdata(seq_mem_wdata), .seq_mem_rdata(smr_v0)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29) ^ 8'h5A);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        host_rd = 0;
        got = host_rdata;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        seq_accept = (which == 0); seq_fail = (which == 1); seq_done = (which == 2);
        @(negedge clk);
        seq_accept = 0; seq_fail = 0; seq_done = 0;
    endtask

    task automatic seq_op(input logic we, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        seq_mem_en = 1; seq_mem_we = we; seq_mem_addr = a; seq_mem_wdata = d;
        @(negedge clk);
        seq_mem_en = 0; seq_mem_we = 0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=00 expected=01");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 rdata", host_rdata, 8'h00);
        check("R1 seq_req", {7'b0, seq_req}, 8'h00);
        check("R1 seq_start", seq_start, 8'h00);
        rd(STAT); check("R1 stat", got, 8'h00);
        rd(CMD);  check("R1 cmd", got, 8'h00);
        rd(PTR);  check("R1 ptr", got, 8'h00);

        // R2 full sweep of pointer and window
        for (int i = 0; i < 256; i++) begin
            wr(PTR, 8'(i));
            rd(PTR); check("R2 ptr readback", got, 8'(i));
            wr(WIN, pat(i));
            exp_mem[i] = pat(i);
        end
        for (int i = 0; i < 256; i++) begin
            wr(PTR, 8'(i));
            rd(WIN); check("R2 window read", got, exp_mem[i]);
        end

        // R4 start register and request flag
        wr(MSG, 8'hA5);
        check("R4 seq_start", seq_start, 8'hA5);
        rd(MSG); check("R4 msg readback", got, 8'hA5);
        wr(CMD, 8'h01);
        check("R4 seq_req", {7'b0, seq_req}, 8'h01);
        rd(CMD); check("R4 cmd readback", got, 8'h01);

        // R3 locked by request
        wr(PTR, 8'h03);
        wr(WIN, ~exp_mem[3]);
        rd(WIN); check("R3 read while req", got, 8'h00);
        // R5 accept
        pulse(0);
        rd(STAT); check("R5 ack set", got, 8'h01);
        wr(WIN, 8'h77);
        rd(WIN); check("R3 read while ack", got, 8'h00);
        wr(CMD, 8'h00);
        check("R4 seq_req low", {7'b0, seq_req}, 8'h00);
        rd(STAT); check("R6 ack held after release", got, 8'h01);
        rd(WIN); check("R3 read after release before done", got, 8'h00);
        // R8 sequencer owns memory
        for (int i = 8'h40; i < 8'h50; i++) begin
            seq_op(1'b1, 8'(i), 8'(i) ^ 8'h3C);
            exp_mem[i] = 8'(i) ^ 8'h3C;
        end
        seq_op(1'b0, 8'h44, 8'h00);
        check("R8 seq read", seq_mem_rdata, 8'h44 ^ 8'h3C);
        pulse(2);
        rd(STAT); check("R6 done clears ack", got, 8'h00);
        wr(PTR, 8'h03);
        rd(WIN); check("R3 blocked write left memory", got, exp_mem[3]);
        for (int i = 8'h40; i < 8'h50; i++) begin
            wr(PTR, 8'(i));
            rd(WIN); check("R8 seq write visible", got, exp_mem[i]);
        end
        seq_op(1'b1, 8'h50, 8'hEE);
        wr(PTR, 8'h50);
        rd(WIN); check("R8 seq write ignored while host owns", got, exp_mem[8'h50]);

        // R6 error behaviour
        wr(CMD, 8'h01);
        rd(STAT); check("R6 stat after request", got, 8'h00);
        pulse(1);
        rd(STAT); check("R5 err set", got, 8'h02);
        wr(CMD, 8'h00);
        rd(STAT); check("R6 err held after release", got, 8'h02);
        pulse(2);
        rd(STAT); check("R6 err held after done", got, 8'h02);
        wr(PTR, 8'h10);
        rd(WIN); check("R3 host owns with err set", got, exp_mem[8'h10]);
        wr(CMD, 8'h01);
        rd(STAT); check("R6 new request clears", got, 8'h00);
        pulse(0); pulse(1);
        rd(STAT); check("R5 ack and err", got, 8'h03);
        wr(CMD, 8'h00); pulse(2);
        rd(STAT); check("R6 only err left", got, 8'h02);
        pulse(0); pulse(1);
        rd(STAT); check("R5 pulses ignored without request", got, 8'h02);
        wr(CMD, 8'h01); wr(CMD, 8'h00);
        rd(STAT); check("R6 cleared by request edge", got, 8'h00);

        // R7 identity
        wr(SEL, 8'h1F);
        rd(ID);  check("R7 version", got, 8'h01);
        check("R10 old layout version", rdata_v0, 8'h00);
        rd(SEL); check("R7 selector readback", got, 8'h1F);
        wr(SEL, 8'h1E);
        rd(ID);  check("R7 other selector", got, 8'h00);

        // R9 unmapped and read-only status
        rd(8'h00); check("R9 unmapped 00", got, 8'h00);
        rd(8'h1F); check("R9 unmapped 1F", got, 8'h00);
        rd(8'hFF); check("R9 unmapped FF", got, 8'h00);
        wr(STAT, 8'h03);
        rd(STAT); check("R9 status write ignored", got, 8'h00);

        // R10 older layout
        wr(8'h0A, 8'h21);
        wr(8'h0D, 8'h9B);
        rd(8'h0D);
        check("R10 old window read", rdata_v0, 8'h9B);
        check("R10 new layout unmapped", got, 8'h00);
        rd(8'h0A); check("R10 old pointer", rdata_v0, 8'h21);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule